// File: doc/BRIEF.md
# Indexed Auto-Increment Host Register Port

This block lets an 8-bit microprocessor reach a 256-byte internal byte store through just two bus locations, chosen by a single select input. When select is low, the access is an address cycle. A write in an address cycle sets an internal index pointer. A read in an address cycle returns the pointer's current value. When select is high, the access is a data cycle. It reads or writes the byte that the pointer names, and the pointer then moves on by one.

Because every data cycle advances the pointer, software sets the start location once and then streams bytes in or out. The low part of the store is meant to hold control and status bytes. Those bytes are reached through the same indexed path as any other location.

The host strobes are asynchronous to the block clock. They pass through a synchroniser chain, and each access takes effect on the trailing edge of its strobe. Chip select, the select bit and the write data are captured while the strobe is seen high, so they must stay stable for the whole strobe.

Top module: `idx_port`

## Requirements
- R1: A write with chip select high and select low (address cycle) loads the write data into the index pointer and changes no byte of the store.
- R2: A write with chip select high and select high (data cycle) stores the write data at the location the pointer held when the strobe began.
- R3: Each data-cycle write advances the pointer by exactly one. For example, after the pointer is loaded with 0x10, three data writes land at 0x10, 0x11 and 0x12.
- R4: A data-cycle read presents the byte at the pointer on the read-data output while the strobe is high. The pointer then advances by one, so back-to-back reads walk consecutive locations.
- R5: An address-cycle read presents the current pointer value on the read-data output and leaves the pointer unchanged.
- R6: A strobe with chip select low changes neither the pointer nor the store, and leaves the read-data output unchanged.
- R7: The pointer is 8 bits wide and wraps from 0xFF to 0x00 when it advances.
- R8: After reset the pointer is 0x00 and the read-data output is 0x00.
- R9: A strobe held high for many clock cycles still counts as a single access: it causes one increment, taken on the strobe's trailing edge.
- R10: All 256 locations, including the low control/status area, are written and read back through the same indexed path.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_cs | input | 1 | Chip select, active high |
| host_rd | input | 1 | Read strobe, active high, asynchronous |
| host_wr | input | 1 | Write strobe, active high, asynchronous |
| host_sel | input | 1 | 0 = address cycle, 1 = data cycle |
| host_din | input | 8 | Write data from the host |
| host_dout | output | 8 | Read data to the host |

## Verification
The in-module assertions watch the pointer on every cycle. They check that an address write loads it, that a data access steps it by one with wrap, that it stays still when no selected access ends, and that an address read never moves it. They also check that the read-data output holds whenever no selected read is in progress.

Only the bench scenarios can show the rest. These are that data lands at the right location and reads back correctly, that long strobes count once, and that deselected accesses leave the store untouched. The bench covers them with random mixed traffic compared against a model, plus directed bursts, the wrap and the reset state.

// File: rtl/idx_port.sv
module idx_port #(
  parameter int DW   = 8,
  parameter int SYNC = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_cs,
  input  logic          host_rd,
  input  logic          host_wr,
  input  logic          host_sel,
  input  logic [DW-1:0] host_din,
  output logic [DW-1:0] host_dout
);

  localparam int DEPTH = 1 << DW;

  logic [SYNC-1:0] rd_sync, wr_sync;
  logic            rd_q, wr_q;
  logic            cs_l, sel_l;
  logic [DW-1:0]   din_l;
  logic [DW-1:0]   ptr;
  logic [DW-1:0]   rd_data;
  logic [DW-1:0]   store [DEPTH];

  wire rd_s    = rd_sync[SYNC-1];
  wire wr_s    = wr_sync[SYNC-1];
  wire rd_fall = rd_q & ~rd_s;
  wire wr_fall = wr_q & ~wr_s;
  wire do_addr = wr_fall & cs_l & ~sel_l;
  wire do_wdat = wr_fall & cs_l & sel_l;
  wire do_rdat = rd_fall & cs_l & sel_l & ~wr_fall;

  assign host_dout = rd_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_sync <= '0;
      wr_sync <= '0;
      rd_q    <= 1'b0;
      wr_q    <= 1'b0;
    end else begin
      rd_sync <= {rd_sync[SYNC-2:0], host_rd};
      wr_sync <= {wr_sync[SYNC-2:0], host_wr};
      rd_q    <= rd_s;
      wr_q    <= wr_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_l  <= 1'b0;
      sel_l <= 1'b0;
      din_l <= '0;
    end else if (rd_s | wr_s) begin
      cs_l  <= host_cs;
      sel_l <= host_sel;
      din_l <= host_din;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      ptr <= '0;
    else if (do_addr)
      ptr <= din_l;
    else if (do_wdat | do_rdat)
      ptr <= ptr + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (do_wdat)
      store[ptr] <= din_l;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      rd_data <= '0;
    else if (rd_s && host_cs)
      rd_data <= host_sel ? store[ptr] : ptr;
  end

  AST_ADDR_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    do_addr |=> ptr == $past(din_l)); // R1

  AST_DATA_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (do_wdat || do_rdat) |=> ptr == DW'($past(ptr) + 1)); // R3

  AST_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    ((do_wdat || do_rdat) && ptr == '1) |=> ptr == '0); // R7

  AST_PTR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_fall || rd_fall) |=> $stable(ptr)); // R6

  AST_ADDR_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_fall && !wr_fall && !sel_l) |=> $stable(ptr)); // R5

  AST_DOUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_s && host_cs) |=> $stable(host_dout)); // R6

endmodule

// File: tb/idx_port_tb.sv
module idx_port_tb;
  localparam int CLK_PERIOD = 10;
  localparam int HOLD = 6;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       host_cs = 1'b0, host_rd = 1'b0, host_wr = 1'b0, host_sel = 1'b0;
  logic [7:0] host_din = '0;
  logic [7:0] host_dout;

  int vectors = 0;
  int errors  = 0;
  logic [7:0] m_ptr;
  logic [7:0] m_mem [256];
  bit         m_known [256];

  always #(CLK_PERIOD/2) clk = ~clk;

  idx_port u_dut (
    .clk(clk), .rst_n(rst_n), .host_cs(host_cs), .host_rd(host_rd),
    .host_wr(host_wr), .host_sel(host_sel), .host_din(host_din),
    .host_dout(host_dout)
  );

  function automatic logic [7:0] exp_read(input logic sel);
    return sel ? m_mem[m_ptr] : m_ptr;
  endfunction

  function automatic logic [7:0] next_ptr(input logic [7:0] p);
    return p + 8'd1;
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_wr(input logic cs, input logic sel, input logic [7:0] d, input int hold);
    @(negedge clk);
    host_cs = cs; host_sel = sel; host_din = d; host_wr = 1'b1;
    idle(hold);
    host_wr = 1'b0;
    idle(HOLD);
    host_cs = 1'b0;
    if (cs) begin
      if (sel) begin m_mem[m_ptr] = d; m_known[m_ptr] = 1'b1; m_ptr = next_ptr(m_ptr); end
      else m_ptr = d;
    end
  endtask

  task automatic bus_rd(input logic cs, input logic sel, input string req, input int hold);
    logic [7:0] e;
    @(negedge clk);
    host_cs = cs; host_sel = sel; host_rd = 1'b1;
    idle(hold);
    if (cs && (!sel || m_known[m_ptr])) begin
      e = exp_read(sel);
      check(req, host_dout, e);
    end
    host_rd = 1'b0;
    idle(HOLD);
    host_cs = 1'b0;
    if (cs && sel) m_ptr = next_ptr(m_ptr);
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    logic [7:0] hold_out;
    void'($urandom(32'd811));
    foreach (m_known[i]) m_known[i] = 1'b0;
    m_ptr = 8'h00;
    idle(4);
    check("R8 dout after reset", host_dout, 8'h00);
    rst_n = 1'b1;
    idle(3);
    check("R8 dout idle", host_dout, 8'h00);
    bus_rd(1'b1, 1'b0, "R8 pointer after reset", HOLD);

    // R1 / R2 / R3: burst from 0x10
    bus_wr(1'b1, 1'b0, 8'h10, HOLD);
    bus_rd(1'b1, 1'b0, "R1 pointer loaded", HOLD);
    bus_wr(1'b1, 1'b1, 8'h55, HOLD);
    bus_wr(1'b1, 1'b1, 8'haa, HOLD);
    bus_wr(1'b1, 1'b1, 8'hbb, HOLD);
    bus_rd(1'b1, 1'b0, "R3 pointer after three writes", HOLD);
    bus_wr(1'b1, 1'b0, 8'h10, HOLD);
    bus_rd(1'b1, 1'b1, "R2 byte at 0x10", HOLD);
    bus_rd(1'b1, 1'b1, "R4 byte at 0x11", HOLD);
    bus_rd(1'b1, 1'b1, "R4 byte at 0x12", HOLD);
    bus_rd(1'b1, 1'b0, "R4 pointer after reads", HOLD);
    bus_rd(1'b1, 1'b0, "R5 address read does not step", HOLD);

    // R1: address write leaves store alone
    bus_wr(1'b1, 1'b0, 8'h11, HOLD);
    bus_wr(1'b1, 1'b0, 8'h11, HOLD);
    bus_rd(1'b1, 1'b1, "R1 store untouched by address writes", HOLD);

    // R6: deselected accesses
    bus_wr(1'b1, 1'b0, 8'h10, HOLD);
    hold_out = host_dout;
    bus_wr(1'b0, 1'b1, 8'h77, HOLD);
    bus_wr(1'b0, 1'b0, 8'hc3, HOLD);
    bus_rd(1'b0, 1'b1, "R6", HOLD);
    check("R6 dout unchanged by deselected read", host_dout, hold_out);
    bus_rd(1'b1, 1'b0, "R6 pointer unchanged", HOLD);
    bus_rd(1'b1, 1'b1, "R6 store unchanged", HOLD);

    // R7: wrap
    bus_wr(1'b1, 1'b0, 8'hfe, HOLD);
    bus_wr(1'b1, 1'b1, 8'h3c, HOLD);
    bus_wr(1'b1, 1'b1, 8'hc3, HOLD);
    bus_rd(1'b1, 1'b0, "R7 pointer wrapped to 0x00", HOLD);
    bus_wr(1'b1, 1'b0, 8'hff, HOLD);
    bus_rd(1'b1, 1'b1, "R7 read at 0xFF", HOLD);
    bus_rd(1'b1, 1'b0, "R7 read wrap to 0x00", HOLD);

    // R9: long strobes
    bus_wr(1'b1, 1'b0, 8'h40, HOLD);
    bus_wr(1'b1, 1'b1, 8'h9e, 40);
    bus_rd(1'b1, 1'b0, "R9 long write steps once", HOLD);
    bus_wr(1'b1, 1'b0, 8'h40, HOLD);
    bus_rd(1'b1, 1'b1, "R9 long read data", 40);
    bus_rd(1'b1, 1'b0, "R9 long read steps once", HOLD);

    // R10: fill whole store, low area included, then read back
    bus_wr(1'b1, 1'b0, 8'h00, HOLD);
    for (int i = 0; i < 256; i++) bus_wr(1'b1, 1'b1, 8'(i * 37 + 5), 3);
    bus_rd(1'b1, 1'b0, "R10 pointer after full fill", HOLD);
    for (int i = 0; i < 256; i++) bus_rd(1'b1, 1'b1, "R10 readback", 4);

    // random mixed traffic
    for (int n = 0; n < 600; n++) begin
      int op = $urandom_range(0, 9);
      logic cs = ($urandom_range(0, 7) != 0);
      int h = $urandom_range(3, 12);
      case (op)
        0, 1:    bus_wr(cs, 1'b0, 8'($urandom), h);
        2, 3, 4: bus_wr(cs, 1'b1, 8'($urandom), h);
        5, 6, 7: bus_rd(cs, 1'b1, "R4 random data read", h);
        default: bus_rd(cs, 1'b0, "R5 random address read", h);
      endcase
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule